// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Fetch Sequencer

This block sits at the front of an interrupt-started transfer engine. Every interrupt source has a pending flag and a routing bit. A source whose routing bit is clear goes straight to the CPU as an ordinary interrupt. A source whose routing bit is set is claimed by the sequencer. It reads that source's entry from a vector table to find where the descriptor lives. It then fetches the descriptor one longword at a time over a simple 32-bit read port. Once the fetch is complete, it presents the unpacked descriptor fields to the transfer engine.

The descriptor has two layouts, chosen by a format input that is sampled when a source is claimed. The compact layout is three longwords and carries 24-bit addresses. The wide layout is four longwords and carries 32-bit addresses. A chain flag in the second mode byte makes the sequencer fetch the next descriptor, which sits directly after the current one in memory. When the last descriptor of a chain has been handled, the sequencer emits a one-cycle clear pulse for the claimed source. The pulse clears either the source's pending flag or its routing bit, as one bit of the final descriptor selects. Moving the data and counting it down are the engine's job.

Top module: `irq_desc_fetcher`

## Requirements
- R1: `cpu_irq` equals `irq_pend & ~route_en` at all times. A pending source whose routing bit is clear never starts a fetch.
- R2: When several routed sources are pending while the block is idle, the lowest index is claimed, and `act_src` shows that index.
- R3: The first read of a claim is at `vec_base + 4*index`. The longword read there is the descriptor pointer. Bits [1:0] of every read address are 00, whatever the low bits of the stored pointer.
- R4: Compact layout (`short_fmt`=1). Word 0 holds mode A in [31:24] and the source address in [23:0]. Word 1 holds mode B in [31:24] and the destination address in [23:0]. Word 2 holds count A in [31:16] and count B in [15:0]. Both addresses are zero-extended to 32 bits.
- R5: Wide layout (`short_fmt`=0). Word 0 holds mode A in [31:24] and mode B in [23:16], and its bits [15:0] are ignored. Word 1 is the source address, word 2 is the destination address, and word 3 holds count A in [31:16] and count B in [15:0].
- R6: The descriptor is read at consecutive longword addresses, three reads for the compact layout and four for the wide one. `rd_req` stays high with a stable `rd_addr` until `rd_ack`. With a memory that acknowledges one cycle after each request, `desc_valid` rises 10 (compact) or 12 (wide) clock edges after the edge at which the pending flag is raised in the environment.
- R7: `desc_valid` and all presented fields stay stable until `xfer_done`. No read is issued while `desc_valid` is high.
- R8: If mode B bit 7 is 1, `xfer_done` starts the fetch of the next descriptor at the current pointer plus 12 (compact) or plus 16 (wide), with no new vector read. In the wide layout, `desc_valid` returns 9 edges after the edge that samples `xfer_done`.
- R9: After `xfer_done` on a descriptor whose mode B bit 7 is 0, exactly one one-cycle pulse follows on bit `act_src`. If mode B bit 6 is 0, the pulse is on `flag_clr`. If mode B bit 6 is 1, the pulse is on `en_clr`.
- R10: While a claim or chain is in progress (`busy`=1), new routed requests are ignored, even higher-priority ones. Such a request is served only after the clear pulse.
- R11: After reset, `rd_req`, `desc_valid`, `busy`, `flag_clr` and `en_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | NUM_SRC | Pending flag for each source |
| route_en | input | NUM_SRC | 1 routes the source to the engine, 0 routes it to the CPU |
| short_fmt | input | 1 | Descriptor layout: 1 compact (3 words), 0 wide (4 words) |
| vec_base | input | 32 | Byte address of vector table entry 0 |
| cpu_irq | output | NUM_SRC | Requests passed to the CPU |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Longword-aligned read address |
| rd_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| rd_data | input | 32 | Read data |
| desc_valid | output | 1 | Decoded descriptor is on the field outputs |
| act_src | output | IDX_W | Index of the claimed source |
| mode_a | output | 8 | Mode byte A |
| mode_b | output | 8 | Mode byte B (bit 7 chain, bit 6 end action) |
| src_addr | output | 32 | Source address |
| dst_addr | output | 32 | Destination address |
| cnt_a | output | 16 | Count A |
| cnt_b | output | 16 | Count B |
| xfer_done | input | 1 | Engine has finished with the presented descriptor |
| flag_clr | output | NUM_SRC | One-cycle pulse that clears a pending flag |
| en_clr | output | NUM_SRC | One-cycle pulse that clears a routing bit |
| busy | output | 1 | A claim is in progress |

## Verification
The bench memory acknowledges every request one cycle after it sees it, so each longword costs two edges. After a pending flag is raised, `desc_valid` is therefore due 10 edges later for the compact layout and 12 for the wide one. After `xfer_done` on a chained wide descriptor, it is due 9 edges later. The clear pulse is visible on the first falling edge after the edge that samples `xfer_done`, and it is gone one edge after that. The bench counts falling edges from each stimulus and compares the count against these figures. It samples all outputs and the logged read addresses only on falling edges, so no check lands on the edge where a value changes.

// File: rtl/dfs_pkg.sv
// Package: shared types and constants of the descriptor fetch sequencer.
// Assumes 32-bit longwords and byte addressing.
package dfs_pkg;
    localparam int WORD_W      = 32;
    localparam int CHAIN_BIT   = 7;   // mode B: another descriptor follows
    localparam int END_ACT_BIT = 6;   // mode B: 1 clears routing bit, 0 clears flag

    typedef struct packed {
        logic [7:0]        mode_a;
        logic [7:0]        mode_b;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [15:0]       cnt_a;
        logic [15:0]       cnt_b;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_DESC,
        ST_PRES,
        ST_DONE
    } state_t;
endpackage

// File: rtl/dfs_prio_arb.sv
// Module: fixed-priority picker. The lowest set request index wins.
// Assumes the requests are already masked by the routing bits.
module dfs_prio_arb #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so that the lowest set bit is the last assignment.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dfs_desc_unpack.sv
// Module: splits the stored descriptor words into fields for either layout.
// Assumes the words are in fetch order. Word 3 is unused in the compact layout.
module dfs_desc_unpack
    import dfs_pkg::*;
(
    input  logic                  short_fmt,
    input  logic [3:0][WORD_W-1:0] words,
    output desc_t                 fields
);
    // Choose the field positions from the layout bit.
    always_comb begin
        if (short_fmt) begin
            fields.mode_a = words[0][31:24];
            fields.src    = {8'h00, words[0][23:0]};
            fields.mode_b = words[1][31:24];
            fields.dst    = {8'h00, words[1][23:0]};
            fields.cnt_a  = words[2][31:16];
            fields.cnt_b  = words[2][15:0];
        end else begin
            fields.mode_a = words[0][31:24];
            fields.mode_b = words[0][23:16];
            fields.src    = words[1];
            fields.dst    = words[2];
            fields.cnt_a  = words[3][31:16];
            fields.cnt_b  = words[3][15:0];
        end
    end
endmodule

// File: rtl/irq_desc_fetcher.sv
// Module: routes each pending source to the CPU or claims it for the engine.
// For a claimed source it reads the vector entry, then fetches the descriptor
// (and any chained ones), presents the fields, and finally pulses a clear
// for the flag or the routing bit.
// Assumes: the read port holds one request at a time, with data valid
// together with rd_ack; the environment applies the clear pulses within one
// cycle.
module irq_desc_fetcher
    import dfs_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] route_en,
    input  logic               short_fmt,
    input  logic [31:0]        vec_base,
    output logic [NUM_SRC-1:0] cpu_irq,
    output logic               rd_req,
    output logic [31:0]        rd_addr,
    input  logic               rd_ack,
    input  logic [31:0]        rd_data,
    output logic               desc_valid,
    output logic [IDX_W-1:0]   act_src,
    output logic [7:0]         mode_a,
    output logic [7:0]         mode_b,
    output logic [31:0]        src_addr,
    output logic [31:0]        dst_addr,
    output logic [15:0]        cnt_a,
    output logic [15:0]        cnt_b,
    input  logic               xfer_done,
    output logic [NUM_SRC-1:0] flag_clr,
    output logic [NUM_SRC-1:0] en_clr,
    output logic               busy
);
    localparam logic [31:0] SHORT_BYTES = 32'd12;
    localparam logic [31:0] FULL_BYTES  = 32'd16;
    localparam logic [31:0] ALIGN_MASK  = 32'hFFFF_FFFC;

    state_t                    state;
    logic [IDX_W-1:0]          src_q;
    logic                      fmt_q;
    logic [31:0]               ptr_q;
    logic [1:0]                word_k;
    logic [3:0][WORD_W-1:0]    words_q;
    logic                      gnt_any;
    logic [IDX_W-1:0]          gnt_idx;
    desc_t                     fields;
    logic [1:0]                last_k;
    logic [31:0]               desc_bytes;
    logic [NUM_SRC-1:0]        src_onehot;

    // Sources whose routing bit is clear go to the CPU.
    assign cpu_irq = irq_pend & ~route_en;

    dfs_prio_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req (irq_pend & route_en),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    dfs_desc_unpack u_unpack (
        .short_fmt (fmt_q),
        .words     (words_q),
        .fields    (fields)
    );

    // Descriptor size and last word index for the latched layout.
    assign last_k     = fmt_q ? 2'd2 : 2'd3;
    assign desc_bytes = fmt_q ? SHORT_BYTES : FULL_BYTES;
    assign src_onehot = NUM_SRC'(1) << src_q;

    // Sequencer: claim a source, read its vector, fetch, present, chain or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            src_q      <= '0;
            fmt_q      <= 1'b0;
            ptr_q      <= '0;
            word_k     <= '0;
            words_q    <= '0;
            rd_req     <= 1'b0;
            rd_addr    <= '0;
            desc_valid <= 1'b0;
            flag_clr   <= '0;
            en_clr     <= '0;
        end else begin
            flag_clr <= '0;
            en_clr   <= '0;
            case (state)
                ST_IDLE: begin
                    if (gnt_any) begin
                        src_q   <= gnt_idx;
                        fmt_q   <= short_fmt;
                        rd_addr <= (vec_base + (32'(gnt_idx) << 2)) & ALIGN_MASK;
                        rd_req  <= 1'b1;
                        state   <= ST_VEC;
                    end
                end
                ST_VEC: begin
                    if (rd_ack) begin
                        ptr_q   <= rd_data & ALIGN_MASK;
                        rd_addr <= rd_data & ALIGN_MASK;
                        word_k  <= '0;
                        state   <= ST_DESC;
                    end
                end
                ST_DESC: begin
                    if (rd_ack) begin
                        words_q[word_k] <= rd_data;
                        if (word_k == last_k) begin
                            rd_req     <= 1'b0;
                            desc_valid <= 1'b1;
                            state      <= ST_PRES;
                        end else begin
                            word_k  <= word_k + 2'd1;
                            rd_addr <= rd_addr + 32'd4;
                        end
                    end
                end
                ST_PRES: begin
                    if (xfer_done) begin
                        desc_valid <= 1'b0;
                        if (fields.mode_b[CHAIN_BIT]) begin
                            ptr_q   <= ptr_q + desc_bytes;
                            rd_addr <= ptr_q + desc_bytes;
                            rd_req  <= 1'b1;
                            word_k  <= '0;
                            state   <= ST_DESC;
                        end else begin
                            if (fields.mode_b[END_ACT_BIT]) en_clr <= src_onehot;
                            else                            flag_clr <= src_onehot;
                            state <= ST_DONE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign act_src  = src_q;
    assign mode_a   = fields.mode_a;
    assign mode_b   = fields.mode_b;
    assign src_addr = fields.src;
    assign dst_addr = fields.dst;
    assign cnt_a    = fields.cnt_a;
    assign cnt_b    = fields.cnt_b;
endmodule

// File: rtl/dfs_checker.sv
// Module: protocol and ordering checks for irq_desc_fetcher.
// Attached to every instance of the top by the bind statement below.
module dfs_checker #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic [31:0]        rd_addr,
    input logic               rd_ack,
    input logic               desc_valid,
    input logic               xfer_done,
    input logic [IDX_W-1:0]   act_src,
    input logic [31:0]        src_addr,
    input logic [31:0]        dst_addr,
    input logic [15:0]        cnt_a,
    input logic [NUM_SRC-1:0] flag_clr,
    input logic [NUM_SRC-1:0] en_clr,
    input logic               busy
);
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[1:0] == 2'b00);

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    a_r7_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !xfer_done |=> desc_valid && $stable(src_addr)
                                     && $stable(dst_addr) && $stable(cnt_a));

    a_r7_no_read_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !rd_req);

    a_r9_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr | en_clr) && ((flag_clr & en_clr) == '0));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_clr | en_clr)) |=> !(|(flag_clr | en_clr)));

    a_r10_source_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> act_src == $past(act_src));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !desc_valid);
endmodule

bind irq_desc_fetcher dfs_checker #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dfs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .desc_valid (desc_valid),
    .xfer_done  (xfer_done),
    .act_src    (act_src),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .cnt_a      (cnt_a),
    .flag_clr   (flag_clr),
    .en_clr     (en_clr),
    .busy       (busy)
);

// File: tb/irq_desc_fetcher_bench.sv
// Directed bench for irq_desc_fetcher. It has a behavioural memory that
// acknowledges one cycle after each request, and an environment model that
// applies the clear pulses to the flag and routing registers.
module irq_desc_fetcher_bench;
    localparam int NUM_SRC = 8;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] irq_pend = '0;
    logic [NUM_SRC-1:0] route_en = '0;
    logic [NUM_SRC-1:0] pend_set = '0, pend_drop = '0, en_set = '0;
    logic               short_fmt = 1'b1;
    logic [31:0]        vec_base = 32'h100;
    logic [NUM_SRC-1:0] cpu_irq;
    logic               rd_req;
    logic [31:0]        rd_addr;
    logic               rd_ack = 1'b0;
    logic [31:0]        rd_data = '0;
    logic               desc_valid;
    logic [IDX_W-1:0]   act_src;
    logic [7:0]         mode_a, mode_b;
    logic [31:0]        src_addr, dst_addr;
    logic [15:0]        cnt_a, cnt_b;
    logic               xfer_done = 1'b0;
    logic [NUM_SRC-1:0] flag_clr, en_clr;
    logic               busy;

    logic [31:0] mem [0:255];
    logic [31:0] rlog [0:63];
    int          log_n = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    irq_desc_fetcher #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_irq_desc_fetcher (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .route_en(route_en),
        .short_fmt(short_fmt), .vec_base(vec_base), .cpu_irq(cpu_irq),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .desc_valid(desc_valid), .act_src(act_src), .mode_a(mode_a), .mode_b(mode_b),
        .src_addr(src_addr), .dst_addr(dst_addr), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .xfer_done(xfer_done), .flag_clr(flag_clr), .en_clr(en_clr), .busy(busy)
    );

    // Memory: acknowledge one cycle after a request and log the address served.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0;
        end else if (rd_req && !rd_ack) begin
            rd_ack      <= 1'b1;
            rd_data     <= mem[rd_addr[9:2]];
            rlog[log_n] <= rd_addr;
            log_n       <= (log_n + 1) % 64;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    // Environment registers: set by the tasks, cleared by the block's pulses.
    always @(posedge clk) begin
        irq_pend <= (irq_pend | pend_set) & ~pend_drop & ~flag_clr;
        route_en <= (route_en | en_set) & ~en_clr;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Pulse one of the environment set/drop vectors for one cycle.
    task automatic raise(input logic [NUM_SRC-1:0] p, input logic [NUM_SRC-1:0] e);
        pend_set = p; en_set = e;
        @(negedge clk);
        pend_set = '0; en_set = '0;
    endtask

    // Count falling edges until desc_valid, starting from the current one.
    task automatic wait_valid(output int n);
        n = 0;
        while (!desc_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "rd_req", 32'(rd_req), 0);
        chk("R11", "desc_valid", 32'(desc_valid), 0);
        chk("R11", "busy", 32'(busy), 0);
        chk("R11", "clears", 32'({flag_clr, en_clr}), 0);
    endtask

    task automatic t_cpu_route();
        int base;
        base = log_n;
        pend_set = 8'h20;
        @(negedge clk);
        pend_set = '0;
        repeat (4) @(negedge clk);
        chk("R1", "cpu_irq", 32'(cpu_irq), 32'h20);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "reads", 32'(log_n - base), 0);
        pend_drop = 8'h20;
        @(negedge clk);
        pend_drop = '0;
        @(negedge clk);
        chk("R1", "cpu_irq cleared", 32'(cpu_irq), 0);
    endtask

    task automatic t_short();
        int base, n;
        short_fmt = 1'b1;
        mem[8'h42] = 32'h0000_0203;            // src2 vector, low bits set
        mem[8'h80] = 32'h11AB_CDEF;
        mem[8'h81] = 32'h0012_3456;            // mode B 00: no chain, clear flag
        mem[8'h82] = 32'hAAAA_5555;
        mem[8'h44] = 32'h0000_0240;            // src4 vector
        mem[8'h90] = 32'h2200_0010;
        mem[8'h91] = 32'h4000_0020;            // mode B 40: clear routing bit
        mem[8'h92] = 32'h0001_0002;
        en_set = 8'h14;
        @(negedge clk);
        en_set = '0;
        base = log_n;
        pend_set = 8'h14;
        wait_valid(n);
        pend_set = '0;
        chk("R6", "compact latency", 32'(n), 10);
        chk("R2", "lowest index wins", 32'(act_src), 2);
        chk("R3", "vector address", rlog[base], 32'h108);
        chk("R3", "aligned pointer", rlog[base+1], 32'h200);
        chk("R6", "word 1 address", rlog[base+2], 32'h204);
        chk("R6", "word 2 address", rlog[base+3], 32'h208);
        chk("R6", "read count", 32'(log_n - base), 4);
        chk("R4", "mode_a", 32'(mode_a), 32'h11);
        chk("R4", "mode_b", 32'(mode_b), 32'h00);
        chk("R4", "src zero-extended", src_addr, 32'h00AB_CDEF);
        chk("R4", "dst", dst_addr, 32'h0012_3456);
        chk("R4", "counts", {cnt_a, cnt_b}, 32'hAAAA_5555);
        repeat (3) @(negedge clk);
        chk("R7", "valid held", 32'(desc_valid), 1);
        chk("R7", "src held", src_addr, 32'h00AB_CDEF);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R9", "flag_clr", 32'(flag_clr), 32'h04);
        chk("R9", "en_clr idle", 32'(en_clr), 0);
        @(negedge clk);
        chk("R9", "pulse ends", 32'(flag_clr), 0);
        base = log_n;
        wait_valid(n);
        chk("R2", "next source served", 32'(act_src), 4);
        chk("R3", "src4 vector", rlog[base], 32'h110);
        chk("R4", "src4 dst", dst_addr, 32'h0000_0020);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R9", "en_clr", 32'(en_clr), 32'h10);
        chk("R9", "flag_clr quiet", 32'(flag_clr), 0);
        repeat (2) @(negedge clk);
        chk("R9", "flag stays, goes to CPU", 32'(cpu_irq), 32'h10);
        chk("R1", "not re-claimed", 32'(busy), 0);
        pend_drop = 8'h10;
        @(negedge clk);
        pend_drop = '0;
    endtask

    task automatic t_full();
        int base, n;
        short_fmt = 1'b0;
        mem[8'h41] = 32'h0000_0300;
        mem[8'hC0] = 32'h5A3C_BEEF;            // low half ignored
        mem[8'hC1] = 32'h8000_1234;
        mem[8'hC2] = 32'hFFFF_0010;
        mem[8'hC3] = 32'h0003_0004;
        base = log_n;
        raise(8'h02, 8'h02);
        wait_valid(n);
        chk("R6", "wide latency", 32'(n + 1), 12);
        chk("R3", "vector address", rlog[base], 32'h104);
        chk("R6", "word 3 address", rlog[base+4], 32'h30C);
        chk("R6", "read count", 32'(log_n - base), 5);
        chk("R5", "mode_a", 32'(mode_a), 32'h5A);
        chk("R5", "mode_b", 32'(mode_b), 32'h3C);
        chk("R5", "src full width", src_addr, 32'h8000_1234);
        chk("R5", "dst", dst_addr, 32'hFFFF_0010);
        chk("R5", "counts", {cnt_a, cnt_b}, 32'h0003_0004);
        pulse_done();
        chk("R9", "flag_clr", 32'(flag_clr), 32'h02);
        @(negedge clk);
    endtask

    task automatic t_chain();
        int base, n;
        short_fmt = 1'b0;
        mem[8'h43] = 32'h0000_0340;
        mem[8'hD0] = 32'h0180_0000;            // chain
        mem[8'hD1] = 32'h0000_1000;
        mem[8'hD2] = 32'h0000_2000;
        mem[8'hD3] = 32'h0001_0002;
        mem[8'hD4] = 32'h0240_0000;            // last, clear routing bit
        mem[8'hD5] = 32'h0000_3000;
        mem[8'hD6] = 32'h0000_4000;
        mem[8'hD7] = 32'h0005_0006;
        mem[8'h40] = 32'h0000_0380;            // src0 vector
        mem[8'hE0] = 32'h0700_0000;
        mem[8'hE1] = 32'h0000_5000;
        mem[8'hE2] = 32'h0000_6000;
        mem[8'hE3] = 32'h0009_000A;
        base = log_n;
        raise(8'h08, 8'h08);
        wait_valid(n);
        chk("R8", "first link src", src_addr, 32'h0000_1000);
        raise(8'h01, 8'h01);
        repeat (2) @(negedge clk);
        chk("R10", "claim kept", 32'(act_src), 3);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R8", "no clear mid-chain", 32'({flag_clr, en_clr}), 0);
        wait_valid(n);
        chk("R8", "chain latency", 32'(n + 1), 9);
        chk("R8", "next link address", rlog[base+5], 32'h350);
        chk("R8", "last word address", rlog[base+8], 32'h35C);
        chk("R10", "no vector read", 32'(log_n - base), 9);
        chk("R10", "claim kept", 32'(act_src), 3);
        chk("R8", "second link src", src_addr, 32'h0000_3000);
        chk("R8", "second link counts", {cnt_a, cnt_b}, 32'h0005_0006);
        pulse_done();
        chk("R9", "en_clr at chain end", 32'(en_clr), 32'h08);
        base = log_n;
        wait_valid(n);
        chk("R10", "deferred source", 32'(act_src), 0);
        chk("R10", "deferred vector", rlog[base], 32'h100);
        chk("R5", "deferred src", src_addr, 32'h0000_5000);
        pulse_done();
        chk("R9", "flag_clr src0", 32'(flag_clr), 32'h01);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cpu_route();
        t_short();
        t_full();
        t_chain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule